// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is one logic cell of a programmable array, written as synthesizable logic. An AND plane, set by configuration inputs, builds product terms from a fixed input bus. That bus typically carries the dedicated inputs and the feedback lines from other cells. Eight logic terms go into a fixed OR. The OR result drives a storage bit that can act as a D, T, SR or JK flip-flop, chosen at run time.

Two more product terms give the cell its control. The first enables the output buffer when the cell runs from a global clock, and becomes the cell's own clock when the product-term clock is chosen. The second clears the stored bit asynchronously. The pin can show the stored bit or the combinational sum, in either polarity. The feedback line can carry the stored bit or the pin level.

Top module: `pld_macrocell`

## Requirements
- R1: A product term is the AND of the literals its map selects. Each term has a 2*N_IN-bit map. Bit 2i connects input i true and bit 2i+1 connects input i complemented. A term with no literal connected is 1. A term with both literals of one input connected is 0.
- R2: The combinational sum is the OR of all N_PT logic terms. In SR and JK modes, the OR of the lower half of the terms is S or J, and the OR of the upper half is R or K.
- R3: `ff_mode` = 0 selects D mode, where the stored bit takes the sum on the active clock edge. `ff_mode` = 1 selects T mode, where the stored bit inverts on the edge when the sum is 1 and holds when it is 0.
- R4: `ff_mode` = 2 selects SR mode. On the edge, S alone sets the bit and R alone clears it. S and R together hold the bit, and so do neither.
- R5: `ff_mode` = 3 selects JK mode. On the edge, J alone sets the bit, K alone clears it, J and K together invert it, and neither holds it.
- R6: `clk_sel[1]` = 1 clocks the register on the rising edge of the OE/clock product term. Otherwise `clk_sel[0]` picks global clock `clk_b` (1) or `clk_a` (0).
- R7: While the clear product term is 1, the stored bit is 0 at once, with no clock edge needed. A clock edge that arrives while the clear term is 1 leaves the bit at 0.
- R8: When a global clock is selected, `pin_oe` equals the OE/clock product term. When the product-term clock is selected, `pin_oe` is always 1.
- R9: `out_reg` = 1 puts the stored bit on `pin_out` and `out_reg` = 0 puts the combinational sum there. `out_inv` = 1 inverts the pin value.
- R10: `fb_reg` = 1 puts the stored bit on `fb_out`. With `fb_reg` = 0, `fb_out` follows `pin_out` while the pin is enabled and follows `pin_in` while it is tri-stated.
- R11: `rst_n` low forces the stored bit to 0 asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Global synchronous clock, bank A |
| clk_b | input | 1 | Global synchronous clock, bank B |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| in_bus | input | N_IN | Array inputs: dedicated inputs and feedback lines |
| pt_map | input | N_PT*2*N_IN | AND-plane programming of the logic terms, term k in bits [k*2*N_IN +: 2*N_IN] |
| oe_clk_map | input | 2*N_IN | Programming of the OE/clock product term |
| clr_map | input | 2*N_IN | Programming of the clear product term |
| ff_mode | input | 2 | Flip-flop type: 0 D, 1 T, 2 SR, 3 JK |
| clk_sel | input | 2 | Clock source: bit 1 selects the product-term clock, bit 0 selects bank B over bank A |
| out_reg | input | 1 | Pin source: 1 registered, 0 combinational |
| fb_reg | input | 1 | Feedback source: 1 registered, 0 pin level |
| out_inv | input | 1 | Pin polarity: 1 active low |
| pin_in | input | 1 | Level seen on the pin from outside |
| pin_out | output | 1 | Value driven to the pin |
| pin_oe | output | 1 | Output buffer enable |
| fb_out | output | 1 | Feedback line into the array |

## Verification
The bench drives every flip-flop type from each of the three clock sources and in both polarities, and compares the result with its own next-state model. A mistake in the S/R or J/K decode shows up as a set-and-reset or J-and-K pair that sets or clears the bit when it should hold or invert it.

It raises the clear term between clock edges and then holds it across an edge. A design whose clear is synchronous, or whose clock wins over the clear, would show a 1 on the pin in one of those checks. It also checks AND terms with no literals and with contradictory literals, the tri-stated feedback path, and the buffer enable that must stay on under the product-term clock. A design with a swapped literal or enable would drive the pin or the feedback line from the wrong source.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
   typedef enum logic [1:0] {
      FF_D  = 2'd0,
      FF_T  = 2'd1,
      FF_SR = 2'd2,
      FF_JK = 2'd3
   } ff_kind_e;
endpackage

// File: rtl/pld_pterm.sv
// One AND-plane row: true/complement literal select per input.
module pld_pterm #(
   parameter int N_IN = 10,
   localparam int MAP_W = 2 * N_IN
) (
   input  logic [N_IN-1:0]  in_bus,
   input  logic [MAP_W-1:0] map,
   output logic             term
);
   always_comb begin
      term = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
         if (map[2*i]   && !in_bus[i]) term = 1'b0;
         if (map[2*i+1] &&  in_bus[i]) term = 1'b0;
      end
   end
endmodule

// File: rtl/pld_ff_core.sv
// Fixed OR, excitation decode, clock select and storage bit.
module pld_ff_core
   import pld_mc_pkg::*;
#(
   parameter int N_PT = 8,
   localparam int HALF = N_PT / 2
) (
   input  logic            clk_a,
   input  logic            clk_b,
   input  logic            pt_clk,
   input  logic [1:0]      clk_sel,
   input  logic            rst_n,
   input  logic            clr,
   input  logic [1:0]      mode,
   input  logic [N_PT-1:0] terms,
   output logic            q,
   output logic            sum
);
   logic grp_lo, grp_hi, reg_clk, nxt;

   assign sum    = |terms;
   assign grp_lo = |terms[HALF-1:0];
   assign grp_hi = |terms[N_PT-1:HALF];

   always_comb begin
      if (clk_sel[1])      reg_clk = pt_clk;
      else if (clk_sel[0]) reg_clk = clk_b;
      else                 reg_clk = clk_a;
   end

   always_comb begin
      case (ff_kind_e'(mode))
         FF_D:    nxt = sum;
         FF_T:    nxt = q ^ sum;
         FF_SR:   nxt = (grp_lo ^ grp_hi) ? grp_lo : q;
         FF_JK:   nxt = (grp_lo & grp_hi) ? ~q : ((grp_lo | grp_hi) ? grp_lo : q);
         default: nxt = q;
      endcase
   end

   always_ff @(posedge reg_clk or posedge clr or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (clr) q <= 1'b0;
      else          q <= nxt;
   end
endmodule

// File: rtl/pld_io_sel.sv
// Output source, polarity, buffer enable and feedback source.
module pld_io_sel (
   input  logic q,
   input  logic sum,
   input  logic oe_t,
   input  logic pt_clk_mode,
   input  logic out_reg,
   input  logic fb_reg,
   input  logic out_inv,
   input  logic pin_in,
   output logic pin_out,
   output logic pin_oe,
   output logic fb_out
);
   assign pin_oe  = pt_clk_mode | oe_t;
   assign pin_out = (out_reg ? q : sum) ^ out_inv;
   assign fb_out  = fb_reg ? q : (pin_oe ? pin_out : pin_in);
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
   parameter int N_IN = 10,
   parameter int N_PT = 8,
   localparam int MAP_W = 2 * N_IN
) (
   input  logic                  clk_a,
   input  logic                  clk_b,
   input  logic                  rst_n,
   input  logic [N_IN-1:0]       in_bus,
   input  logic [N_PT*MAP_W-1:0] pt_map,
   input  logic [MAP_W-1:0]      oe_clk_map,
   input  logic [MAP_W-1:0]      clr_map,
   input  logic [1:0]            ff_mode,
   input  logic [1:0]            clk_sel,
   input  logic                  out_reg,
   input  logic                  fb_reg,
   input  logic                  out_inv,
   input  logic                  pin_in,
   output logic                  pin_out,
   output logic                  pin_oe,
   output logic                  fb_out
);
   if (N_PT < 2 || (N_PT % 2) != 0) begin : g_bad_pt
      $error("pld_macrocell: N_PT must be even and at least 2");
   end
   if (N_IN < 1) begin : g_bad_in
      $error("pld_macrocell: N_IN must be at least 1");
   end

   logic [N_PT-1:0] terms;
   logic            oe_t, clr_t, q_st, sum_all;

   for (genvar k = 0; k < N_PT; k++) begin : g_term
      pld_pterm #(.N_IN(N_IN)) u_term (
         .in_bus (in_bus),
         .map    (pt_map[k*MAP_W +: MAP_W]),
         .term   (terms[k])
      );
   end

   pld_pterm #(.N_IN(N_IN)) u_oe_term (
      .in_bus (in_bus), .map (oe_clk_map), .term (oe_t)
   );
   pld_pterm #(.N_IN(N_IN)) u_clr_term (
      .in_bus (in_bus), .map (clr_map), .term (clr_t)
   );

   pld_ff_core #(.N_PT(N_PT)) u_ff (
      .clk_a   (clk_a),
      .clk_b   (clk_b),
      .pt_clk  (oe_t),
      .clk_sel (clk_sel),
      .rst_n   (rst_n),
      .clr     (clr_t),
      .mode    (ff_mode),
      .terms   (terms),
      .q       (q_st),
      .sum     (sum_all)
   );

   pld_io_sel u_io (
      .q           (q_st),
      .sum         (sum_all),
      .oe_t        (oe_t),
      .pt_clk_mode (clk_sel[1]),
      .out_reg     (out_reg),
      .fb_reg      (fb_reg),
      .out_inv     (out_inv),
      .pin_in      (pin_in),
      .pin_out     (pin_out),
      .pin_oe      (pin_oe),
      .fb_out      (fb_out)
   );
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk (
   input logic       clk_a,
   input logic       rst_n,
   input logic [1:0] clk_sel,
   input logic       fb_reg,
   input logic       pin_in,
   input logic       pin_oe,
   input logic       fb_out,
   input logic       clr_t,
   input logic       q_st
);
   assert_clear_wins_R7: assert property (@(posedge clk_a) disable iff (!rst_n)
      clr_t |-> (q_st == 1'b0));

   assert_ptclk_oe_R8: assert property (@(posedge clk_a) disable iff (!rst_n)
      clk_sel[1] |-> pin_oe);

   assert_fb_reg_R10: assert property (@(posedge clk_a) disable iff (!rst_n)
      fb_reg |-> (fb_out == q_st));

   assert_fb_tristate_R10: assert property (@(posedge clk_a) disable iff (!rst_n)
      (!fb_reg && !pin_oe) |-> (fb_out == pin_in));
endmodule

bind pld_macrocell pld_macrocell_chk u_chk (
   .clk_a   (clk_a),
   .rst_n   (rst_n),
   .clk_sel (clk_sel),
   .fb_reg  (fb_reg),
   .pin_in  (pin_in),
   .pin_oe  (pin_oe),
   .fb_out  (fb_out),
   .clr_t   (clr_t),
   .q_st    (q_st)
);

// File: tb/pld_macrocell_bench.sv
module pld_macrocell_bench;
   localparam int N_IN  = 10;
   localparam int N_PT  = 8;
   localparam int MAP_W = 2 * N_IN;
   localparam int NV    = 16;
   // vector: {src[1:0] (0 clk_a, 1 clk_b, 2 term clock), mode[1:0], inv, data[7:0]}
   localparam logic [12:0] VEC [NV] = '{
      13'b00_00_0_00000001, 13'b01_00_1_00000000, 13'b00_01_0_00010000,
      13'b01_01_1_00000000, 13'b10_01_0_10000000, 13'b00_10_0_00000010,
      13'b01_10_1_00100100, 13'b10_10_0_01000000, 13'b00_10_1_00000000,
      13'b00_11_0_00001000, 13'b01_11_0_00010001, 13'b10_11_1_10000001,
      13'b00_11_0_00100000, 13'b01_11_1_00000000, 13'b10_00_1_11111111,
      13'b00_01_1_00000100
   };

   logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b1;
   logic [N_IN-1:0]       in_bus = '0;
   logic [N_PT*MAP_W-1:0] pt_map = '0;
   logic [MAP_W-1:0]      oe_clk_map = '0, clr_map = '0;
   logic [1:0]            ff_mode = 2'd0, clk_sel = 2'd0;
   logic out_reg = 1'b1, fb_reg = 1'b0, out_inv = 1'b0, pin_in = 1'b0;
   logic pin_out, pin_oe, fb_out;
   int   n_run = 0, n_fail = 0;
   bit   done = 1'b0;
   logic q_model;

   always #5 clk_a = ~clk_a;

   pld_macrocell #(.N_IN(N_IN), .N_PT(N_PT)) u_pld_macrocell (
      .clk_a, .clk_b, .rst_n, .in_bus, .pt_map, .oe_clk_map, .clr_map,
      .ff_mode, .clk_sel, .out_reg, .fb_reg, .out_inv, .pin_in,
      .pin_out, .pin_oe, .fb_out
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic std_maps();
      pt_map = '0;
      for (int k = 0; k < N_PT; k++) pt_map[k*MAP_W + 2*k] = 1'b1;
      oe_clk_map = '0; oe_clk_map[16] = 1'b1;
      clr_map    = '0; clr_map[18]    = 1'b1;
   endtask

   function automatic logic ref_next(logic [1:0] m, logic q, logic [7:0] d);
      logic s, a, b;
      s = |d; a = |d[3:0]; b = |d[7:4];
      case (m)
         2'd0: return s;
         2'd1: return q ^ s;
         2'd2: return (a && !b) ? 1'b1 : ((b && !a) ? 1'b0 : q);
         default: return (a && b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
      endcase
   endfunction

   initial begin
      #100000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      std_maps();
      clk_sel = 2'd1;
      #2 rst_n = 1'b0;
      in_bus = 10'h100;
      #1 chk("R11 reset clears bit", pin_out, 1'b0);

      // R9 combinational path and polarity
      out_reg = 1'b0; in_bus = 10'h120;
      #1 chk("R9 comb sum high", pin_out, 1'b1);
      out_inv = 1'b1;
      #1 chk("R9 comb inverted", pin_out, 1'b0);
      in_bus = 10'h100;
      #1 chk("R9 comb sum low inverted", pin_out, 1'b1);
      out_inv = 1'b0;

      // R1 contradictory and empty terms; R2 sum of all terms
      pt_map = '0;
      for (int k = 0; k < N_PT; k++) pt_map[k*MAP_W +: 2] = 2'b11;
      in_bus = 10'h1FF;
      #1 chk("R1 contradictory terms give 0", pin_out, 1'b0);
      pt_map[0 +: MAP_W] = '0;
      in_bus = 10'h100;
      #1 chk("R1 empty term gives 1", pin_out, 1'b1);
      std_maps();
      in_bus = 10'h180;
      #1 chk("R2 top term reaches sum", pin_out, 1'b1);
      out_reg = 1'b1;

      // release reset with idle clk_b selected, then walk vectors
      @(negedge clk_a); #1 rst_n = 1'b1;
      q_model = 1'b0;
      for (int v = 0; v < NV; v++) begin
         logic [1:0] src, md;
         logic       iv;
         logic [7:0] d;
         {src, md, iv, d} = VEC[v];
         @(negedge clk_a); #1;
         clk_sel = (src == 2'd2) ? 2'd2 : {1'b0, src[0]};
         ff_mode = md; out_inv = iv;
         in_bus  = {1'b0, (src != 2'd2), d};
         q_model = ref_next(md, q_model, d);
         if (src == 2'd0) begin
            @(posedge clk_a); #1;
         end else if (src == 2'd1) begin
            #1 clk_b = 1'b1; #1;
         end else begin
            #1 in_bus[8] = 1'b1; #1;
         end
         case (md)
            2'd0: chk($sformatf("R3 D mode vec %0d src %0d", v, src), pin_out, q_model ^ iv);
            2'd1: chk($sformatf("R3 T mode vec %0d src %0d", v, src), pin_out, q_model ^ iv);
            2'd2: chk($sformatf("R4 SR mode vec %0d src %0d", v, src), pin_out, q_model ^ iv);
            default: chk($sformatf("R5 JK mode vec %0d src %0d", v, src), pin_out, q_model ^ iv);
         endcase
         chk($sformatf("R6 source %0d enable vec %0d", src, v), pin_oe, 1'b1);
         clk_b = 1'b0; in_bus[8] = (src != 2'd2);
      end

      // R7 clear without clock, then clear held across an edge
      @(negedge clk_a); #1;
      clk_sel = 2'd0; ff_mode = 2'd0; out_inv = 1'b0; in_bus = 10'h101;
      @(posedge clk_a); #1 chk("R7 setup bit set", pin_out, 1'b1);
      @(negedge clk_a); #1 in_bus[9] = 1'b1;
      #1 chk("R7 clear acts without clock", pin_out, 1'b0);
      @(posedge clk_a); #1 chk("R7 clear beats clock edge", pin_out, 1'b0);
      @(negedge clk_a); #1 in_bus[9] = 1'b0;
      @(posedge clk_a); #1 chk("R7 clock resumes after clear", pin_out, 1'b1);

      // R8 and R10 buffer enable and feedback sources
      @(negedge clk_a); #1;
      clk_sel = 2'd1; in_bus = 10'h000; pin_in = 1'b1;
      #1 chk("R8 enable follows term low", pin_oe, 1'b0);
      chk("R10 tri-stated feedback high", fb_out, 1'b1);
      pin_in = 1'b0;
      #1 chk("R10 tri-stated feedback low", fb_out, 1'b0);
      in_bus = 10'h100;
      #1 chk("R8 enable follows term high", pin_oe, 1'b1);
      chk("R10 enabled feedback is pin", fb_out, 1'b1);
      out_inv = 1'b1;
      #1 chk("R10 enabled feedback follows polarity", fb_out, 1'b0);
      fb_reg = 1'b1;
      #1 chk("R10 registered feedback", fb_out, 1'b1);
      fb_reg = 1'b0; out_inv = 1'b0;
      in_bus = 10'h000;
      clk_sel = 2'd2;
      #1 chk("R8 term clock forces enable", pin_oe, 1'b1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule